// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block turns an address seen on a local processor bus into the address and cycle attributes that a PCI master engine should issue. It holds a small set of programmable windows. Each window is described by two registers: a base register that says which local addresses the window claims, and a map register that says where those addresses land on PCI and which kind of PCI cycle carries them. The windows at the lower indices are memory windows with a power-of-two size from 1 MB to 2 GB. The last window is a fixed 16 MB window for PCI I/O.

On every cycle the block compares the presented local address against all enabled windows. When several windows claim the same address, the lowest-numbered one supplies the translation. Software can use this to make a large low window temporarily hide a higher one, reprogram the hidden one (for example as a configuration-space window) and then shrink the low window again.

The outputs depend only on the current address and the register contents, with no pipeline stage in between. Register writes land on the next clock edge, so a lookup made in the same cycle as a write still sees the old register contents.

Top module: `lbwin_xlate`

## Requirements
- R1: After reset every window is disabled, so any lookup reports a miss (`win_miss`=1, `win_hit`=0).
- R2: A memory window claims an address only when its base bit 0 (enable) is set and its size code in base bits 7:4 is 0 to 11. Code c gives a window of 2^(20+c) bytes, aligned on its own size, whose start is taken from base bits 31:20. Codes 12 to 15 never match.
- R3: For a memory hit, PCI address bits below 20+c equal the local address bits. Bits from 20+c up to 31 come from map bits 15:4, which give PCI address bits 31:20.
- R4: For a memory hit, `pci_cyc` equals map bits 3:1 (0 interrupt acknowledge, 1 I/O, 3 memory, 5 configuration, 6 memory-multiple). `pci_pref` equals base bit 3, and `pci_swap` equals base bits 9:8.
- R5: Map bit 0 drives `pci_ad_low`. When it is set, PCI address bits 1:0 pass through from the local address. When it is clear, they are driven to zero.
- R6: The I/O window (the last index) matches when its base bit 0 is set and local bits 31:24 equal its base bits 15:8. It outputs map bits 15:8 as PCI bits 31:24 and local bits 23:0 unchanged, with `pci_cyc`=1, `pci_ad_low`=1, `pci_pref`=0 and `pci_swap`=0.
- R7: When more than one enabled window matches, the lowest-numbered one supplies every output, and `win_idx` reports its number.
- R8: When no enabled window matches, `win_miss`=1, `win_hit`=0, and `pci_addr`, `pci_cyc`, `pci_ad_low`, `pci_pref`, `pci_swap` and `win_idx` are all zero.
- R9: Register select 2k writes the base of window k and 2k+1 writes its map. Map and I/O registers take `cfg_wdata[15:0]`. A write takes effect at the next clock edge, a lookup in the write cycle uses the old contents, and select values 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (2k base, 2k+1 map) |
| cfg_wdata | input | 32 | Register write data |
| lb_addr | input | 32 | Local bus address to translate |
| pci_addr | output | 32 | Translated PCI address |
| pci_cyc | output | 3 | PCI cycle type |
| pci_ad_low | output | 1 | Low two address bits come from the host |
| pci_pref | output | 1 | Window is prefetchable |
| pci_swap | output | 2 | Byte-swap mode of the window |
| win_hit | output | 1 | An enabled window matched |
| win_miss | output | 1 | No enabled window matched |
| win_idx | output | 2 | Index of the window that supplied the translation |

## Verification
The bench goes after window edges: the last byte of a 1 MB window and the first byte past it, and the top half of the address space under a 2 GB window. A size decode that is off by one bit position would claim or drop those addresses. It also targets overlap: it enlarges window 0 over window 1 and expects window 0 to win. A reversed priority chain would return window 1's prefetch flag and cycle type instead. Further cases cover the unused size codes 12 and 15, which would match if the decode did not reject them, and forced-zero low address bits, which would leak through if the map bit were ignored. The bench also checks that a lookup in the write cycle still sees the old map, which a write-through path would break, and that selects 6 and 7 leave every window untouched. Random configurations and addresses aimed at the programmed windows are then checked against a model that finds the window by a range comparison.

// File: rtl/lbwin_pkg.sv
package lbwin_pkg;

  localparam int ADDR_W   = 32;
  localparam int PAGE_LSB = 20;
  localparam int CODE_MAX = 11;

  localparam logic [2:0] CYC_IO = 3'd1;

  // memory window base register, packed in stored-bit order
  typedef struct packed {
    logic [11:0] page;
    logic [1:0]  swap;
    logic [3:0]  code;
    logic        pref;
    logic        en;
  } mbase_t;

  // memory window map register
  typedef struct packed {
    logic [11:0] page;
    logic [2:0]  cyc;
    logic        ad_low;
  } mmap_t;

  // I/O window base register
  typedef struct packed {
    logic [7:0] page;
    logic       en;
  } iobase_t;

  // translation result of one candidate window
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [2:0]        cyc;
    logic              ad_low;
    logic              pref;
    logic [1:0]        swap;
  } xlate_t;

  // ones at every address bit that lies at or above the window size
  function automatic logic [ADDR_W-1:0] hi_mask(input logic [3:0] code);
    logic [ADDR_W-1:0] m;
    m = '1;
    if (code > 4'(CODE_MAX)) return '0;
    return m << (PAGE_LSB + int'(code));
  endfunction

  function automatic logic mem_hit(input logic [ADDR_W-1:0] a, input mbase_t b);
    logic [ADDR_W-1:0] m;
    m = hi_mask(b.code);
    return b.en && (b.code <= 4'(CODE_MAX)) &&
           (((a ^ {b.page, 20'h0}) & m) == '0);
  endfunction

  function automatic logic [ADDR_W-1:0] mem_xl(input logic [ADDR_W-1:0] a,
                                               input mmap_t mp,
                                               input logic [3:0] code);
    logic [ADDR_W-1:0] m;
    logic [ADDR_W-1:0] r;
    m = hi_mask(code);
    r = ({mp.page, 20'h0} & m) | (a & ~m);
    if (!mp.ad_low) r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic logic io_hit(input logic [ADDR_W-1:0] a, input iobase_t b);
    return b.en && (a[31:24] == b.page);
  endfunction

  function automatic logic [ADDR_W-1:0] io_xl(input logic [ADDR_W-1:0] a,
                                              input logic [7:0] page);
    return {page, a[23:0]};
  endfunction

endpackage

// File: rtl/lbwin_regs.sv
module lbwin_regs
  import lbwin_pkg::*;
#(
  parameter int MEM_WINS = 2,
  parameter int SEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [31:0]       wdata,
  output mbase_t            mem_base [MEM_WINS],
  output mmap_t             mem_map  [MEM_WINS],
  output iobase_t           io_base,
  output logic [7:0]        io_map
);

  localparam int IO_BASE_SEL = 2 * MEM_WINS;
  localparam int IO_MAP_SEL  = 2 * MEM_WINS + 1;

  // fields of the write word that no register keeps
  logic unused_wbits;
  assign unused_wbits = ^{wdata[31:16] & 16'h0, wdata[19:10], wdata[2:1], io_base_unused_q};

  logic [6:0] io_base_unused_q;
  assign io_base_unused_q = wdata[7:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < MEM_WINS; k++) begin
        mem_base[k] <= '0;
        mem_map[k]  <= '0;
      end
      io_base <= '0;
      io_map  <= '0;
    end else if (we) begin
      for (int k = 0; k < MEM_WINS; k++) begin
        if (sel == SEL_W'(2 * k))
          mem_base[k] <= '{page: wdata[31:20], swap: wdata[9:8], code: wdata[7:4],
                           pref: wdata[3], en: wdata[0]};
        if (sel == SEL_W'(2 * k + 1))
          mem_map[k] <= '{page: wdata[15:4], cyc: wdata[3:1], ad_low: wdata[0]};
      end
      if (sel == SEL_W'(IO_BASE_SEL))
        io_base <= '{page: wdata[15:8], en: wdata[0]};
      if (sel == SEL_W'(IO_MAP_SEL))
        io_map <= wdata[15:8];
    end
  end

endmodule

// File: rtl/lbwin_mem_win.sv
module lbwin_mem_win
  import lbwin_pkg::*;
(
  input  logic [ADDR_W-1:0] lb_addr,
  input  mbase_t            base,
  input  mmap_t             map,
  output logic              match,
  output xlate_t            xl
);

  always_comb begin
    match     = mem_hit(lb_addr, base);
    xl.addr   = mem_xl(lb_addr, map, base.code);
    xl.cyc    = map.cyc;
    xl.ad_low = map.ad_low;
    xl.pref   = base.pref;
    xl.swap   = base.swap;
  end

endmodule

// File: rtl/lbwin_io_win.sv
module lbwin_io_win
  import lbwin_pkg::*;
(
  input  logic [ADDR_W-1:0] lb_addr,
  input  iobase_t           base,
  input  logic [7:0]        map_page,
  output logic              match,
  output xlate_t            xl
);

  always_comb begin
    match     = io_hit(lb_addr, base);
    xl.addr   = io_xl(lb_addr, map_page);
    xl.cyc    = CYC_IO;
    xl.ad_low = 1'b1;
    xl.pref   = 1'b0;
    xl.swap   = 2'b00;
  end

endmodule

// File: rtl/lbwin_prio.sv
module lbwin_prio
  import lbwin_pkg::*;
#(
  parameter int NWIN  = 3,
  parameter int IDX_W = 2
) (
  input  logic [NWIN-1:0]  match,
  input  xlate_t           cand [NWIN],
  output xlate_t           sel,
  output logic [IDX_W-1:0] idx,
  output logic             hit
);

  // walk from the highest index down so the lowest match is written last
  always_comb begin
    sel = '0;
    idx = '0;
    hit = 1'b0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel = cand[i];
        idx = IDX_W'(i);
        hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lbwin_xlate.sv
module lbwin_xlate
  import lbwin_pkg::*;
#(
  parameter int MEM_WINS = 2,
  localparam int NWIN    = MEM_WINS + 1,
  localparam int SEL_W   = $clog2(2 * NWIN),
  localparam int IDX_W   = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [31:0]       lb_addr,
  output logic [31:0]       pci_addr,
  output logic [2:0]        pci_cyc,
  output logic              pci_ad_low,
  output logic              pci_pref,
  output logic [1:0]        pci_swap,
  output logic              win_hit,
  output logic              win_miss,
  output logic [IDX_W-1:0]  win_idx
);

  mbase_t     mem_base [MEM_WINS];
  mmap_t      mem_map  [MEM_WINS];
  iobase_t    io_base;
  logic [7:0] io_map;

  // named internal events for the checker
  logic [NWIN-1:0]           win_match;
  logic [MEM_WINS-1:0]       mem_en;
  logic [MEM_WINS-1:0][15:0] mem_map_bits;
  xlate_t                    cand [NWIN];
  xlate_t                    chosen;

  lbwin_regs #(.MEM_WINS(MEM_WINS), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .mem_base(mem_base),
    .mem_map (mem_map),
    .io_base (io_base),
    .io_map  (io_map)
  );

  for (genvar k = 0; k < MEM_WINS; k++) begin : g_mem
    lbwin_mem_win u_win (
      .lb_addr(lb_addr),
      .base   (mem_base[k]),
      .map    (mem_map[k]),
      .match  (win_match[k]),
      .xl     (cand[k])
    );
    assign mem_en[k]       = mem_base[k].en;
    assign mem_map_bits[k] = mem_map[k];
  end

  lbwin_io_win u_io (
    .lb_addr (lb_addr),
    .base    (io_base),
    .map_page(io_map),
    .match   (win_match[NWIN-1]),
    .xl      (cand[NWIN-1])
  );

  lbwin_prio #(.NWIN(NWIN), .IDX_W(IDX_W)) u_prio (
    .match(win_match),
    .cand (cand),
    .sel  (chosen),
    .idx  (win_idx),
    .hit  (win_hit)
  );

  assign win_miss   = !win_hit;
  assign pci_addr   = chosen.addr;
  assign pci_cyc    = chosen.cyc;
  assign pci_ad_low = chosen.ad_low;
  assign pci_pref   = chosen.pref;
  assign pci_swap   = chosen.swap;

endmodule

// File: rtl/lbwin_xlate_chk.sv
module lbwin_xlate_chk #(
  parameter int MEM_WINS = 2,
  localparam int NWIN    = MEM_WINS + 1,
  localparam int SEL_W   = $clog2(2 * NWIN),
  localparam int IDX_W   = $clog2(NWIN)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic [SEL_W-1:0]          cfg_sel,
  input logic [31:0]               cfg_wdata,
  input logic [31:0]               pci_addr,
  input logic [2:0]                pci_cyc,
  input logic                      pci_ad_low,
  input logic                      pci_pref,
  input logic                      win_hit,
  input logic                      win_miss,
  input logic [IDX_W-1:0]          win_idx,
  input logic [NWIN-1:0]           win_match,
  input logic [MEM_WINS-1:0]       mem_en,
  input logic [MEM_WINS-1:0][15:0] mem_map_bits
);

  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> win_miss);

  p_hit_xor_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit != win_miss);

  p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_miss |-> (pci_addr == '0 && pci_cyc == '0 && !pci_ad_low && !pci_pref &&
                  win_idx == '0));

  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (win_match[win_idx] &&
                 ((win_match & ((NWIN'(1) << win_idx) - NWIN'(1))) == '0)));

  p_any_match_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_match != '0) |-> win_hit);

  for (genvar k = 0; k < MEM_WINS; k++) begin : g_en
    p_disabled_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_en[k] |-> !win_match[k]);
  end

  p_low_bits_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !pci_ad_low) |-> (pci_addr[1:0] == 2'b00));

  p_io_attrs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && win_idx == IDX_W'(NWIN - 1)) |-> (pci_cyc == 3'd1 && pci_ad_low && !pci_pref));

  p_map_load_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_W'(1)) |=> (mem_map_bits[0] == $past(cfg_wdata[15:0])));

endmodule

bind lbwin_xlate lbwin_xlate_chk #(.MEM_WINS(MEM_WINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .pci_addr    (pci_addr),
  .pci_cyc     (pci_cyc),
  .pci_ad_low  (pci_ad_low),
  .pci_pref    (pci_pref),
  .win_hit     (win_hit),
  .win_miss    (win_miss),
  .win_idx     (win_idx),
  .win_match   (win_match),
  .mem_en      (mem_en),
  .mem_map_bits(mem_map_bits)
);

// File: tb/lbwin_xlate_tb.sv
module lbwin_xlate_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] lb_addr = '0;
  logic [31:0] pci_addr;
  logic [2:0]  pci_cyc;
  logic        pci_ad_low, pci_pref, win_hit, win_miss;
  logic [1:0]  pci_swap, win_idx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] sh_base [3];
  logic [15:0] sh_map  [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  lbwin_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .lb_addr(lb_addr), .pci_addr(pci_addr), .pci_cyc(pci_cyc), .pci_ad_low(pci_ad_low),
    .pci_pref(pci_pref), .pci_swap(pci_swap), .win_hit(win_hit), .win_miss(win_miss),
    .win_idx(win_idx)
  );

  // reference: find the window by an explicit range test on the shadow copy
  task automatic model(input logic [31:0] a, output logic [44:0] e);
    logic        h, adl, pf;
    logic [31:0] pa;
    logic [2:0]  cy;
    logic [1:0]  sw, ix;
    h = 0; pa = 0; cy = 0; adl = 0; pf = 0; sw = 0; ix = 0;
    for (int k = 0; k < 2; k++) begin
      int unsigned code;
      logic [63:0] span, start, a64;
      code = sh_base[k][7:4];
      if (!h && sh_base[k][0] && code < 12) begin
        span  = 64'd1 << (20 + code);
        start = {32'd0, sh_base[k][31:20], 20'd0} & ~(span - 64'd1);
        a64   = {32'd0, a};
        if (a64 >= start && a64 < start + span) begin
          logic [63:0] t;
          t  = ({32'd0, sh_map[k][15:4], 20'd0} & ~(span - 64'd1)) | (a64 & (span - 64'd1));
          pa = t[31:0];
          if (!sh_map[k][0]) pa[1:0] = 2'b00;
          h = 1; cy = sh_map[k][3:1]; adl = sh_map[k][0];
          pf = sh_base[k][3]; sw = sh_base[k][9:8]; ix = 2'(k);
        end
      end
    end
    if (!h && sh_base[2][0] && a[31:24] == sh_base[2][15:8]) begin
      h = 1; pa = {sh_map[2][15:8], a[23:0]}; cy = 3'd1; adl = 1; pf = 0; sw = 0; ix = 2'd2;
    end
    e = {h, !h, pa, cy, adl, pf, sw, ix};
  endtask

  function automatic logic [44:0] actual();
    return {win_hit, win_miss, pci_addr, pci_cyc, pci_ad_low, pci_pref, pci_swap, win_idx};
  endfunction

  task automatic check_now(input logic [31:0] a, input string req);
    logic [44:0] e, got;
    lb_addr = a;
    #1;
    model(a, e);
    got = actual();
    checks++;
    if (got !== e) begin
      failures++;
      $display("FAIL %s addr=%h actual hit=%b miss=%b pci=%h cyc=%0d adl=%b pf=%b sw=%0d idx=%0d expected hit=%b miss=%b pci=%h cyc=%0d adl=%b pf=%b sw=%0d idx=%0d",
               req, a, got[44], got[43], got[42:11], got[10:8], got[7], got[6], got[5:4], got[3:2],
               e[44], e[43], e[42:11], e[10:8], e[7], e[6], e[5:4], e[3:2]);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (sel < 3'd6) begin
      if (sel[0]) sh_map[sel >> 1] = d[15:0];
      else sh_base[sel >> 1] = (sel == 3'd4) ? {16'd0, d[15:0]} : d;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed_d;
    seed_d = $urandom(32'd4242);
    for (int k = 0; k < 3; k++) begin sh_base[k] = 0; sh_map[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check_now(32'h4000_0000, "R1");
    check_bit(win_miss, 1'b1, "R1 miss after reset");

    // R2 R3 R5: 256 MB memory window, low bits forced to zero
    wr(3'd0, 32'h4000_0081);
    wr(3'd1, 32'h0000_4006);
    check_now(32'h4123_4567, "R3");
    check_bit(pci_addr[1:0] == 2'b00, 1'b1, "R5 forced low bits");

    // R4 R5: prefetch, swap, memory-multiple, low bits passed
    wr(3'd2, 32'h5000_0289);
    wr(3'd3, 32'h0000_900D);
    check_now(32'h5ABC_DEF3, "R4");
    check_bit(pci_pref, 1'b1, "R4 prefetch");

    // R6: I/O window, then disabled I/O window
    wr(3'd4, 32'hFFFF_6001);
    wr(3'd5, 32'h0000_1200);
    check_now(32'h60AB_CDEF, "R6");
    wr(3'd4, 32'h0000_6000);
    check_now(32'h60AB_CDEF, "R6 disabled");

    // R7: enlarge window 0 to 512 MB so it hides window 1
    wr(3'd0, 32'h4000_0091);
    check_now(32'h5000_0013, "R7");
    check_bit(pci_pref, 1'b0, "R7 window 0 attributes win");

    // R2: 1 MB window edges, unused size codes
    wr(3'd0, 32'h0000_0000);
    wr(3'd2, 32'h7000_0001);
    wr(3'd3, 32'h0000_A007);
    check_now(32'h700F_FFFF, "R2 last byte");
    check_now(32'h7010_0000, "R2 past end");
    wr(3'd2, 32'h7000_00C1);
    check_now(32'h7000_0000, "R2 code 12");
    wr(3'd2, 32'h7000_00F1);
    check_now(32'h7000_0000, "R2 code 15");

    // R2 R3: 2 GB window
    wr(3'd2, 32'h8000_00B1);
    check_now(32'hFFFF_FFFF, "R2 2GB top");
    check_now(32'h7FFF_FFFF, "R8 below 2GB");

    // R9: lookup in the write cycle sees old map, new map next cycle
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'd3; cfg_wdata = 32'h0000_3006;
    check_now(32'h8123_4567, "R9 old value");
    @(negedge clk);
    cfg_we = 0;
    sh_map[1] = 16'h3006;
    check_now(32'h8123_4567, "R9 new value");

    // R9: selects 6 and 7 change nothing
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    check_now(32'h8123_4567, "R9 unused select");
    check_now(32'h1000_0000, "R9 unused select miss");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom;
      if (r % 4 == 0) begin
        logic [2:0]  sel;
        logic [31:0] d;
        sel = 3'($urandom % 6);
        d = $urandom;
        if (sel == 3'd0 || sel == 3'd2) begin
          d[7:4] = 4'($urandom % 14);
          d[0]   = ($urandom % 4) != 0;
        end
        if (sel == 3'd4) d[0] = ($urandom % 4) != 0;
        wr(sel, d);
      end else begin
        int unsigned k;
        logic [31:0] a;
        k = $urandom % 3;
        a = $urandom;
        if (k < 2) a[31:20] = sh_base[k][31:20];
        else a[31:24] = sh_base[2][15:8];
        if ($urandom % 8 == 0) a[31 - ($urandom % 12)] ^= 1'b1;
        @(negedge clk);
        check_now(a, "R7 R3 random");
      end
    end

    finish_run();
  end

endmodule